// File: doc/BRIEF.md
# Sync-Gated Power Meter with Histograms

This block measures the power of one complex sample stream. Each accepted sample is squared, I·I + Q·Q. A sync pulse starts a measurement. The meter skips a programmed number of samples, then integrates over a programmed window length. For that window it reports the summed power, the largest single-sample power and two histogram counts. Each histogram count is the number of window samples whose squared magnitude is above its own threshold.

The meter can run once per sync or repeat with a programmed period. It has three operating modes: off, normal (every valid sample counts) and gated (only valid samples with the gate input high count). Finished results reach the host in one of two ways. In interrupt mode, every finished window loads the result registers and raises an interrupt, and the host clears it with a done pulse. In handshake mode, the host holds a request; the next finished window loads the results and raises an acknowledge, and the results then stay frozen until the host drops the request.

Top module: `sync_power_meter`

## Requirements
- R1: The power of an accepted sample is smp_i² + smp_q². res_pwr reports the sum over the window of these powers. res_peak reports the largest single power in the window.
- R2: Accepted samples are numbered from 0, starting with the first cycle after the sync cycle. A sample that arrives in the sync cycle itself is not counted. Samples cfg_dly through cfg_dly+cfg_len-1 form the window. The window completes on sample cfg_dly+cfg_len-1, and the outputs reflect it right after the clock edge that accepts that sample. With cfg_len = 0 no window ever completes.
- R3: The accumulator is 2·SMP_W+CNT_W bits wide. A full window of maximum-magnitude samples (cfg_len = 2^CNT_W-1) therefore gives the exact sum, and res_peak never exceeds the working sum.
- R4: When cfg_oneshot = 1, no further window completes after one has completed, until the next sync.
- R5: When cfg_oneshot = 0, numbering restarts at 0 after sample cfg_ivl-1, and the partial sums are discarded at that point. Every period then yields a result. If cfg_ivl < cfg_dly+cfg_len, no result is ever produced.
- R6: cfg_mode selects the operating mode. A value of 0 or 3 means off: the meter idles, clears its partial sums and ignores sync. A value of 1 counts every sample with smp_vld high. A value of 2 counts, for both numbering and accumulation, only samples with smp_vld and smp_gate both high.
- R7: res_hist_a (res_hist_b) counts the window samples whose power is strictly greater than cfg_thr_a (cfg_thr_b). Both thresholds are in squared-magnitude units.
- R8: When cfg_handshake = 0 (interrupt mode), each completed window loads all result outputs and sets irq. A host_rd_done pulse clears irq at the next edge. A completion in the same cycle as host_rd_done wins, and irq stays set. ack stays 0 in this mode.
- R9: When cfg_handshake = 1 (handshake mode), irq is 0. The first completion seen while host_rd_req is high and ack is low loads the results and sets ack. While ack is high, the results hold. ack clears at the edge that samples host_rd_req low. Completions with host_rd_req low change nothing.
- R10: A sync in the middle of a cycle discards the partial sums and restarts numbering at 0.
- R11: After reset, all result outputs, irq and ack are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample valid strobe |
| smp_i | input | SMP_W | In-phase sample, signed |
| smp_q | input | SMP_W | Quadrature sample, signed |
| smp_gate | input | 1 | Gate qualifier used in gated mode |
| sync_in | input | 1 | Sync pulse that starts a measurement |
| cfg_mode | input | 2 | 0/3 off, 1 normal, 2 gated |
| cfg_oneshot | input | 1 | 1 one window per sync, 0 periodic |
| cfg_dly | input | CNT_W | Samples skipped before the window |
| cfg_len | input | CNT_W | Window length in samples |
| cfg_ivl | input | CNT_W | Repeat period in samples |
| cfg_thr_a | input | 2·SMP_W | Histogram A threshold (squared magnitude) |
| cfg_thr_b | input | 2·SMP_W | Histogram B threshold (squared magnitude) |
| cfg_handshake | input | 1 | 0 interrupt hand-off, 1 request/acknowledge |
| host_rd_done | input | 1 | Interrupt-mode clear pulse |
| host_rd_req | input | 1 | Handshake-mode read request level |
| res_pwr | output | 2·SMP_W+CNT_W | Latched window power sum |
| res_peak | output | 2·SMP_W | Latched window peak power |
| res_hist_a | output | CNT_W | Latched count above threshold A |
| res_hist_b | output | CNT_W | Latched count above threshold B |
| irq | output | 1 | Result-ready interrupt |
| ack | output | 1 | Handshake acknowledge |

## Verification
The handshake assertions assume the host treats host_rd_req as a level that it holds until it sees ack. The bench raises the request, waits for ack across several later completions, and only then lowers it. The window properties assume the configuration fields change only while the meter is off or just before a sync. The stimulus therefore changes configuration at the falling edge between scenarios and always issues a fresh sync afterwards.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_NORMAL  = 2'd1,
        MODE_GATED   = 2'd2,
        MODE_OFF_ALT = 2'd3
    } meter_mode_e;

    typedef enum logic {
        HANDOFF_IRQ = 1'b0,
        HANDOFF_REQ = 1'b1
    } handoff_e;

    function automatic logic mode_runs(meter_mode_e m);
        return (m == MODE_NORMAL) || (m == MODE_GATED);
    endfunction

    function automatic logic sample_counts(meter_mode_e m, logic vld, logic gate);
        return vld && ((m != MODE_GATED) || gate);
    endfunction

endpackage

// File: rtl/spm_window_seq.sv
module spm_window_seq #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             strobe,
    input  logic             sync_in,
    input  logic             oneshot,
    input  logic [CNT_W-1:0] dly,
    input  logic [CNT_W-1:0] len,
    input  logic [CNT_W-1:0] ivl,
    output logic             take,
    output logic             in_win,
    output logic             last,
    output logic             restart
);
    localparam int EW = CNT_W + 1;

    logic             active;
    logic [CNT_W-1:0] pos;
    logic [EW-1:0]    pos_e;
    logic [EW-1:0]    win_beg;
    logic [EW-1:0]    win_end;
    logic             wrap;

    always_comb begin
        pos_e   = {1'b0, pos};
        win_beg = {1'b0, dly};
        win_end = {1'b0, dly} + {1'b0, len};
        in_win  = (pos_e >= win_beg) && (pos_e < win_end);
        last    = (len != '0) && ((pos_e + EW'(1)) == win_end);
        wrap    = !oneshot && (pos == (ivl - CNT_W'(1)));
        take    = run && active && strobe && !sync_in;
        restart = !run || sync_in || (take && wrap);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            active <= 1'b0;
            pos    <= '0;
        end else if (sync_in) begin
            active <= 1'b1;
            pos    <= '0;
        end else if (take) begin
            if (last && oneshot) begin
                active <= 1'b0;
                pos    <= '0;
            end else if (wrap) begin
                pos <= '0;
            end else begin
                pos <= pos + CNT_W'(1);
            end
        end
    end

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> !active); // R6

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (take && last && oneshot) |=> !active); // R4

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        (run && sync_in) |=> (pos == '0)); // R10

endmodule

// File: rtl/spm_accum.sv
module spm_accum #(
    parameter int PWR_W = 24,
    parameter int CNT_W = 12,
    parameter int ACC_W = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             in_win,
    input  logic             last,
    input  logic             restart,
    input  logic [PWR_W-1:0] pwr,
    input  logic [PWR_W-1:0] thr_a,
    input  logic [PWR_W-1:0] thr_b,
    output logic             done,
    output logic [ACC_W-1:0] fin_acc,
    output logic [PWR_W-1:0] fin_peak,
    output logic [CNT_W-1:0] fin_ha,
    output logic [CNT_W-1:0] fin_hb
);
    logic [ACC_W-1:0] acc;
    logic [PWR_W-1:0] peak;
    logic [CNT_W-1:0] ha;
    logic [CNT_W-1:0] hb;
    logic             use_smp;

    always_comb begin
        use_smp  = take && in_win;
        done     = use_smp && last;
        fin_acc  = acc + ACC_W'(pwr);
        fin_peak = (pwr > peak) ? pwr : peak;
        fin_ha   = ha + {{(CNT_W-1){1'b0}}, (pwr > thr_a)};
        fin_hb   = hb + {{(CNT_W-1){1'b0}}, (pwr > thr_b)};
    end

    always_ff @(posedge clk) begin
        if (rst || done || restart) begin
            acc  <= '0;
            peak <= '0;
            ha   <= '0;
            hb   <= '0;
        end else if (use_smp) begin
            acc  <= fin_acc;
            peak <= fin_peak;
            ha   <= fin_ha;
            hb   <= fin_hb;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        use_smp |-> (fin_acc >= acc)); // R3

    AST_PEAK_LE_SUM: assert property (@(posedge clk) disable iff (rst)
        ACC_W'(peak) <= acc); // R3

endmodule

// File: rtl/spm_handoff.sv
module spm_handoff #(
    parameter int PWR_W = 24,
    parameter int CNT_W = 12,
    parameter int ACC_W = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_mode,
    input  logic             done,
    input  logic [ACC_W-1:0] fin_acc,
    input  logic [PWR_W-1:0] fin_peak,
    input  logic [CNT_W-1:0] fin_ha,
    input  logic [CNT_W-1:0] fin_hb,
    input  logic             rd_done,
    input  logic             rd_req,
    output logic [ACC_W-1:0] res_pwr,
    output logic [PWR_W-1:0] res_peak,
    output logic [CNT_W-1:0] res_ha,
    output logic [CNT_W-1:0] res_hb,
    output logic             irq,
    output logic             ack
);
    import spm_pkg::*;

    handoff_e ho;
    logic     load;

    always_comb begin
        ho   = handoff_e'(hs_mode);
        load = (ho == HANDOFF_IRQ) ? done : (done && rd_req && !ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_pwr  <= '0;
            res_peak <= '0;
            res_ha   <= '0;
            res_hb   <= '0;
            irq      <= 1'b0;
            ack      <= 1'b0;
        end else begin
            if (load) begin
                res_pwr  <= fin_acc;
                res_peak <= fin_peak;
                res_ha   <= fin_ha;
                res_hb   <= fin_hb;
            end
            if (ho == HANDOFF_IRQ) begin
                ack <= 1'b0;
                if (done)
                    irq <= 1'b1;
                else if (rd_done)
                    irq <= 1'b0;
            end else begin
                irq <= 1'b0;
                if (!rd_req)
                    ack <= 1'b0;
                else if (load)
                    ack <= 1'b1;
            end
        end
    end

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(rd_req)); // R9

    AST_RES_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(ack)) |-> $stable(res_pwr)); // R9

    AST_NO_IRQ_HS: assert property (@(posedge clk) disable iff (rst)
        $past(hs_mode) |-> !irq); // R9

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_done) && !$past(done) && !$past(hs_mode)) |-> !irq); // R8

endmodule

// File: rtl/sync_power_meter.sv
module sync_power_meter #(
    parameter  int SMP_W = 12,
    parameter  int CNT_W = 12,
    localparam int PWR_W = 2 * SMP_W,
    localparam int ACC_W = PWR_W + CNT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic signed [SMP_W-1:0] smp_q,
    input  logic                    smp_gate,
    input  logic                    sync_in,
    input  logic [1:0]              cfg_mode,
    input  logic                    cfg_oneshot,
    input  logic [CNT_W-1:0]        cfg_dly,
    input  logic [CNT_W-1:0]        cfg_len,
    input  logic [CNT_W-1:0]        cfg_ivl,
    input  logic [PWR_W-1:0]        cfg_thr_a,
    input  logic [PWR_W-1:0]        cfg_thr_b,
    input  logic                    cfg_handshake,
    input  logic                    host_rd_done,
    input  logic                    host_rd_req,
    output logic [ACC_W-1:0]        res_pwr,
    output logic [PWR_W-1:0]        res_peak,
    output logic [CNT_W-1:0]        res_hist_a,
    output logic [CNT_W-1:0]        res_hist_b,
    output logic                    irq,
    output logic                    ack
);
    import spm_pkg::*;

    meter_mode_e             mode;
    logic                    run;
    logic                    strobe;
    logic signed [PWR_W-1:0] sq_i;
    logic signed [PWR_W-1:0] sq_q;
    logic [PWR_W-1:0]        pwr;

    logic take, in_win, last, restart;
    logic             done;
    logic [ACC_W-1:0] fin_acc;
    logic [PWR_W-1:0] fin_peak;
    logic [CNT_W-1:0] fin_ha;
    logic [CNT_W-1:0] fin_hb;

    always_comb begin
        mode   = meter_mode_e'(cfg_mode);
        run    = mode_runs(mode);
        strobe = sample_counts(mode, smp_vld, smp_gate);
        sq_i   = PWR_W'(smp_i) * PWR_W'(smp_i);
        sq_q   = PWR_W'(smp_q) * PWR_W'(smp_q);
        pwr    = $unsigned(sq_i) + $unsigned(sq_q);
    end

    spm_window_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .strobe  (strobe),
        .sync_in (sync_in),
        .oneshot (cfg_oneshot),
        .dly     (cfg_dly),
        .len     (cfg_len),
        .ivl     (cfg_ivl),
        .take    (take),
        .in_win  (in_win),
        .last    (last),
        .restart (restart)
    );

    spm_accum #(.PWR_W(PWR_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .in_win   (in_win),
        .last     (last),
        .restart  (restart),
        .pwr      (pwr),
        .thr_a    (cfg_thr_a),
        .thr_b    (cfg_thr_b),
        .done     (done),
        .fin_acc  (fin_acc),
        .fin_peak (fin_peak),
        .fin_ha   (fin_ha),
        .fin_hb   (fin_hb)
    );

    spm_handoff #(.PWR_W(PWR_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_ho (
        .clk      (clk),
        .rst      (rst),
        .hs_mode  (cfg_handshake),
        .done     (done),
        .fin_acc  (fin_acc),
        .fin_peak (fin_peak),
        .fin_ha   (fin_ha),
        .fin_hb   (fin_hb),
        .rd_done  (host_rd_done),
        .rd_req   (host_rd_req),
        .res_pwr  (res_pwr),
        .res_peak (res_peak),
        .res_ha   (res_hist_a),
        .res_hb   (res_hist_b),
        .irq      (irq),
        .ack      (ack)
    );

    AST_PEAK_LE_RESULT: assert property (@(posedge clk) disable iff (rst)
        ACC_W'(res_peak) <= res_pwr); // R1

endmodule

// File: tb/test_sync_power_meter.sv
module test_sync_power_meter;
    localparam int SMP_W = 12;
    localparam int CNT_W = 12;
    localparam int PWR_W = 2 * SMP_W;
    localparam int ACC_W = PWR_W + CNT_W;
    localparam int CMOD  = 1 << CNT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 0, smp_gate = 0, sync_in = 0;
    logic signed [SMP_W-1:0] smp_i = '0, smp_q = '0;
    logic [1:0] cfg_mode = 2'd0;
    logic cfg_oneshot = 1'b1;
    logic [CNT_W-1:0] cfg_dly = '0, cfg_len = '0, cfg_ivl = '0;
    logic [PWR_W-1:0] cfg_thr_a = '0, cfg_thr_b = '0;
    logic cfg_handshake = 1'b0, host_rd_done = 1'b0, host_rd_req = 1'b0;
    logic [ACC_W-1:0] res_pwr;
    logic [PWR_W-1:0] res_peak;
    logic [CNT_W-1:0] res_hist_a, res_hist_b;
    logic irq, ack;

    always #2ns clk = ~clk;

    sync_power_meter #(.SMP_W(SMP_W), .CNT_W(CNT_W)) i_sync_power_meter (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
        .smp_gate(smp_gate), .sync_in(sync_in), .cfg_mode(cfg_mode),
        .cfg_oneshot(cfg_oneshot), .cfg_dly(cfg_dly), .cfg_len(cfg_len),
        .cfg_ivl(cfg_ivl), .cfg_thr_a(cfg_thr_a), .cfg_thr_b(cfg_thr_b),
        .cfg_handshake(cfg_handshake), .host_rd_done(host_rd_done),
        .host_rd_req(host_rd_req), .res_pwr(res_pwr), .res_peak(res_peak),
        .res_hist_a(res_hist_a), .res_hist_b(res_hist_b), .irq(irq), .ack(ack)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 0;
    bit finished = 0;
    string phase = "R11";

    task automatic chk(string req, longint act, longint exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int     m_act, m_pos, m_ha, m_hb, m_fha, m_fhb;
    longint m_acc, m_peak, m_facc, m_fpeak;
    longint e_pwr, e_peak;
    int     e_ha, e_hb, e_irq, e_ack;

    always @(posedge clk) begin
        int  p, ii, qq;
        bit  run, stb, done, wrap;
        if (rst) begin
            m_act = 0; m_pos = 0; m_acc = 0; m_peak = 0; m_ha = 0; m_hb = 0;
            e_pwr = 0; e_peak = 0; e_ha = 0; e_hb = 0; e_irq = 0; e_ack = 0;
        end else begin
            run  = (cfg_mode == 2'd1) || (cfg_mode == 2'd2);
            stb  = smp_vld && ((cfg_mode != 2'd2) || smp_gate);
            ii   = int'(smp_i);
            qq   = int'(smp_q);
            p    = ii * ii + qq * qq;
            done = 0;
            if (!run) begin
                m_act = 0; m_pos = 0; m_acc = 0; m_peak = 0; m_ha = 0; m_hb = 0;
            end else if (sync_in) begin
                m_act = 1; m_pos = 0; m_acc = 0; m_peak = 0; m_ha = 0; m_hb = 0;
            end else if (m_act != 0 && stb) begin
                if (m_pos >= int'(cfg_dly) && m_pos < int'(cfg_dly) + int'(cfg_len)) begin
                    m_acc += p;
                    if (p > m_peak) m_peak = p;
                    if (p > int'(cfg_thr_a)) m_ha++;
                    if (p > int'(cfg_thr_b)) m_hb++;
                end
                wrap = !cfg_oneshot && (m_pos == (int'(cfg_ivl) + CMOD - 1) % CMOD);
                if (cfg_len != 0 && m_pos == int'(cfg_dly) + int'(cfg_len) - 1) begin
                    done = 1;
                    m_facc = m_acc; m_fpeak = m_peak; m_fha = m_ha; m_fhb = m_hb;
                    m_acc = 0; m_peak = 0; m_ha = 0; m_hb = 0;
                end
                if (wrap) begin
                    m_acc = 0; m_peak = 0; m_ha = 0; m_hb = 0;
                end
                if (done && cfg_oneshot) begin
                    m_act = 0; m_pos = 0;
                end else if (wrap) m_pos = 0;
                else m_pos = (m_pos + 1) % CMOD;
            end
            if (!cfg_handshake) begin
                e_ack = 0;
                if (done) begin
                    e_pwr = m_facc; e_peak = m_fpeak; e_ha = m_fha; e_hb = m_fhb; e_irq = 1;
                end else if (host_rd_done) e_irq = 0;
            end else begin
                e_irq = 0;
                if (!host_rd_req) e_ack = 0;
                else if (done && e_ack == 0) begin
                    e_pwr = m_facc; e_peak = m_fpeak; e_ha = m_fha; e_hb = m_fhb; e_ack = 1;
                end
            end
            started = 1;
        end
    end

    always @(negedge clk) begin
        if (started && !rst && !finished) begin
            chk(phase, longint'(res_pwr), e_pwr, "model res_pwr");
            chk(phase, longint'(res_peak), e_peak, "model res_peak");
            chk(phase, longint'(res_hist_a), e_ha, "model res_hist_a");
            chk(phase, longint'(res_hist_b), e_hb, "model res_hist_b");
            chk(phase, longint'(irq), e_irq, "model irq");
            chk(phase, longint'(ack), e_ack, "model ack");
        end
    end

    // one cycle: set inputs at falling edge, return at next falling edge
    task automatic drv(bit v, int i, int q, bit g, bit s);
        smp_vld = v; smp_i = SMP_W'(i); smp_q = SMP_W'(q); smp_gate = g; sync_in = s;
        @(negedge clk);
    endtask

    task automatic sync_pulse();
        drv(0, 0, 0, 0, 1);
    endtask

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        phase = "R11";
        chk("R11", res_pwr, 0, "reset res_pwr");
        chk("R11", irq, 0, "reset irq");
        chk("R11", ack, 0, "reset ack");

        // one-shot normal window: delay 2, length 4
        phase = "R2";
        cfg_mode = 2'd1; cfg_oneshot = 1; cfg_dly = 2; cfg_len = 4;
        cfg_thr_a = 8; cfg_thr_b = 16;
        sync_pulse();
        for (int k = 0; k < 5; k++) drv(1, k, 0, 0, 0);
        chk("R2", irq, 0, "irq before last window sample");
        drv(1, 5, 0, 0, 0);
        chk("R2", irq, 1, "irq after last window sample");
        chk("R1", res_pwr, 54, "window sum");
        chk("R1", res_peak, 25, "window peak");
        chk("R7", res_hist_a, 3, "hist above 8");
        chk("R7", res_hist_b, 1, "hist strictly above 16");

        phase = "R4";
        for (int k = 0; k < 10; k++) drv(1, 7, 0, 0, 0);
        chk("R4", res_pwr, 54, "oneshot no second result");

        phase = "R8";
        host_rd_done = 1; drv(0, 0, 0, 0, 0);
        host_rd_done = 0; drv(0, 0, 0, 0, 0);
        chk("R8", irq, 0, "done pulse clears irq");

        // periodic: delay 1, length 3, period 6, done held high
        phase = "R5";
        cfg_oneshot = 0; cfg_dly = 1; cfg_len = 3; cfg_ivl = 6;
        host_rd_done = 1;
        sync_pulse();
        pulses = 0;
        for (int k = 0; k < 18; k++) begin
            drv(1, 2, 0, 0, 0);
            if (irq) pulses++;
        end
        chk("R5", pulses, 3, "periodic result count");
        chk("R5", res_pwr, 12, "periodic sum");
        chk("R8", irq, 0, "completion beats done only on its cycle");

        // period too short
        cfg_ivl = 3;
        sync_pulse();
        pulses = 0;
        for (int k = 0; k < 20; k++) begin
            drv(1, 9, 0, 0, 0);
            if (irq) pulses++;
        end
        chk("R5", pulses, 0, "short period never completes");
        chk("R5", res_pwr, 12, "short period keeps results");
        host_rd_done = 0;

        // gated mode
        phase = "R6";
        cfg_mode = 2'd2; cfg_oneshot = 1; cfg_dly = 0; cfg_len = 3;
        sync_pulse();
        for (int k = 1; k <= 8; k++) drv(1, k, 0, k % 2, 0);
        chk("R6", res_pwr, 35, "gated sum");
        chk("R6", res_peak, 25, "gated peak");
        chk("R6", irq, 1, "gated irq");
        host_rd_done = 1; drv(0, 0, 0, 0, 0);
        host_rd_done = 0;

        // off mode
        cfg_mode = 2'd0;
        sync_pulse();
        for (int k = 0; k < 10; k++) drv(1, 20, 0, 1, 0);
        chk("R6", res_pwr, 35, "off mode no update");
        chk("R6", irq, 0, "off mode no irq");

        // sync mid-cycle
        phase = "R10";
        cfg_mode = 2'd1; cfg_oneshot = 1; cfg_dly = 0; cfg_len = 4;
        sync_pulse();
        drv(1, 10, 0, 0, 0);
        drv(1, 10, 0, 0, 0);
        sync_pulse();
        for (int k = 0; k < 4; k++) drv(1, 1, 0, 0, 0);
        chk("R10", res_pwr, 4, "restart discards partial");
        chk("R10", res_peak, 1, "restart discards partial peak");

        // handshake mode
        phase = "R9";
        cfg_handshake = 1; host_rd_req = 0;
        cfg_oneshot = 0; cfg_dly = 0; cfg_len = 2; cfg_ivl = 2;
        sync_pulse();
        for (int k = 0; k < 6; k++) drv(1, 5, 0, 0, 0);
        chk("R9", res_pwr, 4, "no load without request");
        chk("R9", irq, 0, "irq low in handshake");
        chk("R9", ack, 0, "ack low without request");
        host_rd_req = 1;
        drv(1, 5, 0, 0, 0);
        chk("R9", ack, 0, "ack waits for completion");
        drv(1, 5, 0, 0, 0);
        chk("R9", ack, 1, "ack after completion");
        chk("R9", res_pwr, 50, "loaded on request");
        for (int k = 0; k < 4; k++) drv(1, 6, 0, 0, 0);
        chk("R9", res_pwr, 50, "frozen while ack");
        host_rd_req = 0;
        drv(0, 0, 0, 0, 0);
        chk("R9", ack, 0, "ack drops after request release");
        drv(1, 6, 0, 0, 0);
        drv(1, 6, 0, 0, 0);
        chk("R9", res_pwr, 50, "no load after release without request");

        // full-scale window
        phase = "R3";
        cfg_handshake = 0; cfg_oneshot = 1; cfg_dly = 0; cfg_len = CNT_W'(CMOD - 1);
        cfg_thr_a = 0; cfg_thr_b = PWR_W'(8388608);
        sync_pulse();
        for (int k = 0; k < CMOD - 1; k++) drv(1, -2048, -2048, 0, 0);
        chk("R3", res_pwr, 64'd34351349760, "full-scale sum");
        chk("R3", res_peak, 8388608, "full-scale peak");
        chk("R7", res_hist_a, CMOD - 1, "all samples above zero");
        chk("R7", res_hist_b, 0, "none strictly above max");

        drv(0, 0, 0, 0, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule